// File: doc/BRIEF.md
# USB Host Clock and Reset Bring-Up Sequencer

This block is a synchronous state machine that brings a USB host controller out of power-up. It drives the enables and reset releases of the host clocking and PHY domains in a fixed order, then presents constant tuning values for the ports and a frame-length adjust value. Each wait in the order is a cycle count. The block derives these counts at elaboration time from a system clock frequency parameter, rounding up and never going below one cycle.

Software-side users share the controller through a start/stop reference count. Only the start that takes the count from zero to one runs the sequence. If the host is already out of reset when that start arrives, the whole reset order is skipped and only the tuning step runs. The block holds `busy` high while it works and pulses `done` once when the tuning outputs become valid.

Top module: `usb_bringup_seq`

## Requirements
- R1: After reset every output is 0, including `host_div`, the tuning fields and `frame_adj`.
- R2: A start taken with a count of 0 raises `busy` on the accepting edge. The next edge raises `if_en`, and `if_en` is set before any reset output changes.
- R3: One edge after `if_en`, a single edge raises `phy_por` and clears the PHY release, the host release, both divider enables and both divider releases.
- R4: `host_div` is written on the edge after R3. Its value comes from the quotient q = SYS_CLK_HZ / 130 MHz: q=0 gives 1, q=1..4 gives q, q=5 gives 4, q=6..7 gives 6, q=8..11 gives 8, and q>=12 gives 12.
- R5: `hdiv_en` rises one edge after `host_div` is written, and `hdiv_rel` rises on the edge after that. `phy_por` falls DIV_WAIT_CYC+1 edges after `hdiv_rel` rises.
- R6: `phy_test_rst` rises ceil(PHY_WAIT_NS)+1 edges after `phy_por` falls. It stays high for ceil(TEST_RST_NS)+1 edges. `odiv_rel` rises ceil(TEST_SETTLE_NS)+1 edges after it falls. Each ceil is a cycle count with a minimum of 1.
- R7: `odiv_en` rises one edge after `odiv_rel`. `phy_rst_rel` rises DIV_WAIT_CYC+1 edges later, and `host_rst_rel` rises ceil(PHY_REL_NS)+1 edges after that.
- R8: One edge after `host_rst_rel` rises, `done` pulses for one cycle and `busy` falls on the same edge. From that edge onward both ports show voltage-reference tune 15, rise tune 1 and pre-emphasis tune 1, and `frame_adj` shows 0x20. Port p occupies slice p of each packed tuning vector.
- R9: If `host_rst_rel` is already high when a sequence starts, `done` pulses two edges after acceptance, and no reset, enable or test-reset output changes.
- R10: A start with a count of 1 or more only increments the count. A stop decrements the count, stays at 0 when the count is already 0, and changes no output.
- R11: Start and stop requests that arrive while `busy` is high are ignored and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request, one cycle |
| stop_req | input | 1 | Stop request, one cycle |
| if_en | output | 1 | Interface enable |
| phy_por | output | 1 | PHY power-on reset |
| phy_rst_rel | output | 1 | PHY reset release |
| host_rst_rel | output | 1 | Host reset release |
| hdiv_en | output | 1 | Host clock divider enable |
| hdiv_rel | output | 1 | Host clock divider reset release |
| odiv_en | output | 1 | OHCI clock divider enable |
| odiv_rel | output | 1 | OHCI clock divider reset release |
| phy_test_rst | output | 1 | PHY test-reset pulse |
| host_div | output | HDIV_W | Host divider select |
| port_vref_tune | output | NPORTS*VREF_W | Voltage-reference tune per port |
| port_rise_tune | output | NPORTS*RISE_W | Rise-time tune per port |
| port_preemph_tune | output | NPORTS*PRE_W | Pre-emphasis tune per port |
| frame_adj | output | FLA_W | Frame-length adjust value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is a register, so each step lands a whole number of edges after acceptance. The count is 1 at acceptance and grows by one per action step and by the wait length plus one per timed step. In a full run at 250 MHz with a 2000 ns PHY wait, `done` is due on edge 900 and `if_en` on edge 2. In a skip run, `done` is due on edge 3. The bench drives requests on a falling edge and counts falling edges after the accepting rising edge. It records the exact index at which each output first rises or falls and compares it with counts recomputed from the requirement formulas. The reference count is observed only through whether a later start runs a sequence.

// File: rtl/usbseq_pkg.sv
package usbseq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_IFEN, ST_RESET, ST_DIVSEL, ST_HDEN, ST_HDREL, ST_W64A,
    ST_PORCLR, ST_WPHY, ST_TRHI, ST_WT10, ST_TRLO, ST_WT20, ST_OREL,
    ST_OEN, ST_W64B, ST_PREL, ST_W1US, ST_HREL, ST_TUNE
  } seq_state_e;

  // Wait length in cycles, rounded up, never below one.
  function automatic longint ns_to_cycles(longint ns, longint hz);
    longint c;
    c = (ns * hz + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // Non-linear host divider choice from the 130 MHz quotient.
  function automatic int hdiv_from_hz(longint hz);
    longint q;
    q = hz / 64'sd130_000_000;
    if (q == 0)  return 1;
    if (q <= 4)  return int'(q);
    if (q == 5)  return 4;
    if (q <= 7)  return 6;
    if (q <= 11) return 8;
    return 12;
  endfunction

endpackage

// File: rtl/usbseq_refcnt.sv
module usbseq_refcnt #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic first
);
  logic [CNT_W-1:0] count_q;

  assign first = inc && !dec && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (inc && !dec && (count_q != '1))
      count_q <= count_q + CNT_W'(1);
    else if (dec && !inc && (count_q != '0))
      count_q <= count_q - CNT_W'(1);
  end

  // R10: the launching start leaves exactly one user
  p_first_to_one_r10: assert property (@(posedge clk) disable iff (rst)
    first |=> (count_q == CNT_W'(1)));
  // R10: a stop at zero does not wrap
  p_floor_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && (count_q == '0)) |=> (count_q == '0));
endmodule

// File: rtl/usbseq_timer.sv
module usbseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign expire = (cnt_q == W'(1));

  // R6: every wait is at least one cycle long
  p_load_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
  // R6: the last-cycle flag lasts one cycle unless reloaded
  p_expire_single_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/usb_bringup_seq.sv
module usb_bringup_seq
  import usbseq_pkg::*;
#(
  parameter longint SYS_CLK_HZ     = 250_000_000,
  parameter longint PHY_WAIT_NS    = 1_000_000,
  parameter longint TEST_RST_NS    = 10,
  parameter longint TEST_SETTLE_NS = 20,
  parameter longint PHY_REL_NS     = 1000,
  parameter int     DIV_WAIT_CYC   = 64,
  parameter int     NPORTS         = 2,
  parameter int     VREF_W         = 4,
  parameter int     RISE_W         = 2,
  parameter int     PRE_W          = 2,
  parameter int     VREF_VAL       = 15,
  parameter int     RISE_VAL       = 1,
  parameter int     PRE_VAL        = 1,
  parameter int     HDIV_W         = 4,
  parameter int     FLA_W          = 6,
  parameter int     FLA_VAL        = 32,
  parameter int     CNT_W          = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_req,
  input  logic                     stop_req,
  output logic                     if_en,
  output logic                     phy_por,
  output logic                     phy_rst_rel,
  output logic                     host_rst_rel,
  output logic                     hdiv_en,
  output logic                     hdiv_rel,
  output logic                     odiv_en,
  output logic                     odiv_rel,
  output logic                     phy_test_rst,
  output logic [HDIV_W-1:0]        host_div,
  output logic [NPORTS*VREF_W-1:0] port_vref_tune,
  output logic [NPORTS*RISE_W-1:0] port_rise_tune,
  output logic [NPORTS*PRE_W-1:0]  port_preemph_tune,
  output logic [FLA_W-1:0]         frame_adj,
  output logic                     busy,
  output logic                     done
);
  localparam longint CYC_PHY  = ns_to_cycles(PHY_WAIT_NS, SYS_CLK_HZ);
  localparam longint CYC_TRST = ns_to_cycles(TEST_RST_NS, SYS_CLK_HZ);
  localparam longint CYC_SETL = ns_to_cycles(TEST_SETTLE_NS, SYS_CLK_HZ);
  localparam longint CYC_PREL = ns_to_cycles(PHY_REL_NS, SYS_CLK_HZ);
  localparam longint CYC_DIV  = longint'(DIV_WAIT_CYC);
  localparam longint MAX_A    = (CYC_PHY > CYC_PREL) ? CYC_PHY : CYC_PREL;
  localparam longint MAX_B    = (CYC_TRST > CYC_SETL) ? CYC_TRST : CYC_SETL;
  localparam longint MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam longint MAX_WAIT = (MAX_C > CYC_DIV) ? MAX_C : CYC_DIV;
  localparam int     TMR_W    = $clog2(MAX_WAIT + 1);
  localparam int     HDIV_VAL = hdiv_from_hz(SYS_CLK_HZ);

  seq_state_e state_q;
  logic if_en_q, por_q, phy_rel_q, host_rel_q, hden_q, hdrel_q;
  logic oden_q, odrel_q, trst_q, busy_q, done_q, tune_on_q;
  logic [HDIV_W-1:0] hdiv_q;

  logic launch;
  logic tmr_load, tmr_expire;
  logic [TMR_W-1:0] tmr_val;

  usbseq_refcnt #(.CNT_W(CNT_W)) u_refcnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (start_req && !busy_q),
    .dec   (stop_req && !busy_q),
    .first (launch)
  );

  usbseq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_HDREL, ST_OEN: begin tmr_load = 1'b1; tmr_val = TMR_W'(CYC_DIV);  end
      ST_PORCLR:        begin tmr_load = 1'b1; tmr_val = TMR_W'(CYC_PHY);  end
      ST_TRHI:          begin tmr_load = 1'b1; tmr_val = TMR_W'(CYC_TRST); end
      ST_TRLO:          begin tmr_load = 1'b1; tmr_val = TMR_W'(CYC_SETL); end
      ST_PREL:          begin tmr_load = 1'b1; tmr_val = TMR_W'(CYC_PREL); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      if_en_q    <= 1'b0;
      por_q      <= 1'b0;
      phy_rel_q  <= 1'b0;
      host_rel_q <= 1'b0;
      hden_q     <= 1'b0;
      hdrel_q    <= 1'b0;
      oden_q     <= 1'b0;
      odrel_q    <= 1'b0;
      trst_q     <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      tune_on_q  <= 1'b0;
      hdiv_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (launch) begin
          busy_q  <= 1'b1;
          state_q <= ST_IFEN;
        end
        ST_IFEN: begin
          if_en_q <= 1'b1;
          state_q <= host_rel_q ? ST_TUNE : ST_RESET;
        end
        ST_RESET: begin
          por_q      <= 1'b1;
          host_rel_q <= 1'b0;
          phy_rel_q  <= 1'b0;
          hden_q     <= 1'b0;
          hdrel_q    <= 1'b0;
          oden_q     <= 1'b0;
          odrel_q    <= 1'b0;
          state_q    <= ST_DIVSEL;
        end
        ST_DIVSEL: begin hdiv_q  <= HDIV_W'(HDIV_VAL); state_q <= ST_HDEN;   end
        ST_HDEN:   begin hden_q  <= 1'b1;              state_q <= ST_HDREL;  end
        ST_HDREL:  begin hdrel_q <= 1'b1;              state_q <= ST_W64A;   end
        ST_W64A:   if (tmr_expire) state_q <= ST_PORCLR;
        ST_PORCLR: begin por_q   <= 1'b0;              state_q <= ST_WPHY;   end
        ST_WPHY:   if (tmr_expire) state_q <= ST_TRHI;
        ST_TRHI:   begin trst_q  <= 1'b1;              state_q <= ST_WT10;   end
        ST_WT10:   if (tmr_expire) state_q <= ST_TRLO;
        ST_TRLO:   begin trst_q  <= 1'b0;              state_q <= ST_WT20;   end
        ST_WT20:   if (tmr_expire) state_q <= ST_OREL;
        ST_OREL:   begin odrel_q <= 1'b1;              state_q <= ST_OEN;    end
        ST_OEN:    begin oden_q  <= 1'b1;              state_q <= ST_W64B;   end
        ST_W64B:   if (tmr_expire) state_q <= ST_PREL;
        ST_PREL:   begin phy_rel_q <= 1'b1;            state_q <= ST_W1US;   end
        ST_W1US:   if (tmr_expire) state_q <= ST_HREL;
        ST_HREL:   begin host_rel_q <= 1'b1;           state_q <= ST_TUNE;   end
        ST_TUNE: begin
          tune_on_q <= 1'b1;
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign port_vref_tune[p*VREF_W +: VREF_W]  = tune_on_q ? VREF_W'(VREF_VAL) : '0;
    assign port_rise_tune[p*RISE_W +: RISE_W]  = tune_on_q ? RISE_W'(RISE_VAL) : '0;
    assign port_preemph_tune[p*PRE_W +: PRE_W] = tune_on_q ? PRE_W'(PRE_VAL)   : '0;
  end

  assign frame_adj    = tune_on_q ? FLA_W'(FLA_VAL) : '0;
  assign if_en        = if_en_q;
  assign phy_por      = por_q;
  assign phy_rst_rel  = phy_rel_q;
  assign host_rst_rel = host_rel_q;
  assign hdiv_en      = hden_q;
  assign hdiv_rel     = hdrel_q;
  assign odiv_en      = oden_q;
  assign odiv_rel     = odrel_q;
  assign phy_test_rst = trst_q;
  assign host_div     = hdiv_q;
  assign busy         = busy_q;
  assign done         = done_q;

  // R5: host divider running before the PHY leaves power-on reset
  p_div_before_por_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(por_q) |-> (hden_q && hdrel_q));
  // R6: test reset only after power-on reset is gone
  p_trst_no_por_r6: assert property (@(posedge clk) disable iff (rst)
    trst_q |-> !por_q);
  // R7: host released last
  p_host_last_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rel_q) |-> (phy_rel_q && oden_q && odrel_q));
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8: tuning valid and busy clear when done shows
  p_done_state_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && tune_on_q));
  // R11: no new sequence can launch while one runs
  p_no_launch_busy_r11: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !launch);
  // R10: idle without launch leaves every output alone
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !launch) |=> $stable({if_en_q, por_q, phy_rel_q, host_rel_q,
      hden_q, hdrel_q, oden_q, odrel_q, trst_q, hdiv_q, tune_on_q, busy_q}));
endmodule

// File: tb/usb_bringup_seq_test.sv
module usb_bringup_seq_test;
  localparam int     NP     = 2;
  localparam longint HZ     = 250_000_000;
  localparam longint PHY_NS = 2000;
  localparam int     NDIV   = 6;
  localparam int     NCMD   = 9;
  // command table: [4:3] 1=start 2=stop, [2] inject during busy, [1] expect busy, [0] expect full run
  localparam logic [4:0] CMD_TAB [NCMD] = '{
    5'b01_1_1_1, 5'b01_0_0_0, 5'b10_0_0_0, 5'b10_0_0_0, 5'b01_0_1_0,
    5'b10_0_0_0, 5'b10_0_0_0, 5'b01_0_1_0, 5'b01_0_0_0 };
  localparam longint HZ_TAB  [NDIV] = '{100_000_000, 520_000_000, 650_000_000,
                                        910_000_000, 1_430_000_000, 1_560_000_000};
  localparam int     DIV_TAB [NDIV] = '{1, 4, 4, 6, 8, 12};

  logic clk = 1'b0, rst = 1'b1, start_req = 1'b0, stop_req = 1'b0;
  logic if_en, phy_por, phy_rst_rel, host_rst_rel, hdiv_en, hdiv_rel;
  logic odiv_en, odiv_rel, phy_test_rst, busy, done;
  logic [3:0] host_div;
  logic [NP*4-1:0] vref;
  logic [NP*2-1:0] rise, pre;
  logic [5:0] fadj;
  logic [3:0] div_obs [NDIV];

  int total = 0, fails = 0;
  int rise_at [10];
  int fall_at [10];
  int done_n;
  logic busy_seen;

  always #2 clk = ~clk;

  usb_bringup_seq #(.SYS_CLK_HZ(HZ), .PHY_WAIT_NS(PHY_NS)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .if_en(if_en), .phy_por(phy_por), .phy_rst_rel(phy_rst_rel),
    .host_rst_rel(host_rst_rel), .hdiv_en(hdiv_en), .hdiv_rel(hdiv_rel),
    .odiv_en(odiv_en), .odiv_rel(odiv_rel), .phy_test_rst(phy_test_rst),
    .host_div(host_div), .port_vref_tune(vref), .port_rise_tune(rise),
    .port_preemph_tune(pre), .frame_adj(fadj), .busy(busy), .done(done));

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic a0, a1, a2, a3, a4, a5, a6, a7, a8, a9, a10;
    logic [3:0] hd;
    logic [NP*4-1:0] v;
    logic [NP*2-1:0] r, pe;
    logic [5:0] f;
    usb_bringup_seq #(.SYS_CLK_HZ(HZ_TAB[g]), .PHY_WAIT_NS(PHY_NS)) u_d (
      .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
      .if_en(a0), .phy_por(a1), .phy_rst_rel(a2), .host_rst_rel(a3),
      .hdiv_en(a4), .hdiv_rel(a5), .odiv_en(a6), .odiv_rel(a7),
      .phy_test_rst(a8), .host_div(hd), .port_vref_tune(v),
      .port_rise_tune(r), .port_preemph_tune(pe), .frame_adj(f),
      .busy(a9), .done(a10));
    assign div_obs[g] = hd;
  end

  function automatic longint cyc(longint ns);
    longint c;
    c = (ns * HZ + 999_999_999) / 1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] snap();
    return {done, phy_test_rst, host_rst_rel, phy_rst_rel, odiv_en, odiv_rel,
            hdiv_rel, hdiv_en, phy_por, if_en};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // issue one command; record edge index of each first rise and fall
  task automatic run_cmd(input logic [1:0] cmd, input logic inject, input int limit);
    logic [9:0] prev, cur;
    prev = snap();
    for (int i = 0; i < 10; i++) begin rise_at[i] = 0; fall_at[i] = 0; end
    done_n = 0;
    busy_seen = 1'b0;
    @(negedge clk);
    start_req = (cmd == 2'd1);
    stop_req  = (cmd == 2'd2);
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (n == 1) begin start_req = 1'b0; stop_req = 1'b0; busy_seen = busy; end
      if (inject && n == 100) stop_req = 1'b1;
      if (inject && n == 101) begin stop_req = 1'b0; start_req = 1'b1; end
      if (inject && n == 102) start_req = 1'b0;
      cur = snap();
      for (int i = 0; i < 10; i++) begin
        if (!prev[i] && cur[i] && rise_at[i] == 0) rise_at[i] = n;
        if (prev[i] && !cur[i] && fall_at[i] == 0) fall_at[i] = n;
      end
      prev = cur;
      if (cur[9]) begin done_n = n; break; end
    end
  endtask

  task automatic chk_tune(input string req);
    chk(req, vref, {NP{4'd15}});
    chk(req, rise, {NP{2'd1}});
    chk(req, pre, {NP{2'd1}});
    chk(req, fadj, 6'h20);
    chk(req, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    longint w64, p, t10, t20, t1u, e_hrel, e_porf, e_trr, e_trf, e_orel, e_phyr, e_host;
    w64 = 64; p = cyc(PHY_NS); t10 = cyc(10); t20 = cyc(20); t1u = cyc(1000);
    e_hrel = 6;
    e_porf = e_hrel + w64 + 1;
    e_trr  = e_porf + p + 1;
    e_trf  = e_trr + t10 + 1;
    e_orel = e_trf + t20 + 1;
    e_phyr = e_orel + 1 + w64 + 1;
    e_host = e_phyr + t1u + 1;

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ctl", {snap(), busy}, 0);
    chk("R1 data", {host_div, vref, rise, pre, fadj}, 0);

    for (int k = 0; k < NCMD; k++) begin
      logic [4:0] e;
      e = CMD_TAB[k];
      run_cmd(e[4:3], e[2], e[1] ? 2000 : 6);
      chk($sformatf("R10 R11 busy step %0d", k), busy_seen, e[1]);
      if (!e[1]) begin
        // R10: no output moved, no done
        chk($sformatf("R10 quiet step %0d", k), done_n, 0);
        for (int i = 0; i < 10; i++)
          chk($sformatf("R10 edge step %0d sig %0d", k, i), rise_at[i] + fall_at[i], 0);
      end else if (e[0]) begin
        chk("R2 if_en", rise_at[0], 2);
        chk("R3 por on", rise_at[1], 3);
        chk("R5 hdiv_en", rise_at[2], 5);
        chk("R5 hdiv_rel", rise_at[3], e_hrel);
        chk("R5 por off", fall_at[1], e_porf);
        chk("R6 trst on", rise_at[8], e_trr);
        chk("R6 trst off", fall_at[8], e_trf);
        chk("R6 odiv_rel", rise_at[4], e_orel);
        chk("R7 odiv_en", rise_at[5], e_orel + 1);
        chk("R7 phy_rel", rise_at[6], e_phyr);
        chk("R7 host_rel", rise_at[7], e_host);
        chk("R8 done", done_n, e_host + 1);
        chk("R4 host_div 250MHz", host_div, 1);
        chk_tune("R8 tune");
        @(negedge clk);
        chk("R8 done pulse", done, 0);
        chk("R11 host held", host_rst_rel, 1);
      end else begin
        chk($sformatf("R9 done step %0d", k), done_n, 3);
        chk($sformatf("R9 por step %0d", k), rise_at[1] + fall_at[1] + rise_at[8], 0);
        chk($sformatf("R9 host step %0d", k), fall_at[7] + fall_at[2] + fall_at[5], 0);
        chk_tune("R9 tune");
        @(negedge clk);
      end
    end

    // R4: divider selection for other clock rates
    for (int g = 0; g < NDIV; g++)
      chk($sformatf("R4 hz %0d", HZ_TAB[g]), div_obs[g], DIV_TAB[g]);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", {snap(), busy, host_div, vref, fadj}, 0);
    finish_run();
  end
endmodule